// File: doc/BRIEF.md
# 4x4 Inverse Transform Reconstructor

The block rebuilds one 4x4 tile of 10-bit pixels from a 4x4 tile of signed residual coefficients and a matching 4x4 tile of prediction pixels. Coefficients go into an internal store before a run, either as a whole tile in one cycle or one entry at a time. A start pulse latches the prediction tile. The block then runs a 4-point integer kernel across the rows and a second time down the columns, with a rounding bias applied between the two passes. Each result is scaled down by 64, added to its prediction pixel with saturation and clipped to the 10-bit range.

Reconstructed pixels leave one row of four per cycle, in row order, each row marked by a valid strobe and its row number. A done flag accompanies the final row. In that same cycle the coefficient store is cleared, so the next tile only has to load its non-zero entries. While a tile is in flight, the block ignores further start pulses and coefficient loads.

Top module: `idct4_recon`

## Requirements
- R1: After reset, busy, out_valid and done are low and every coefficient entry is zero, so a run with no load returns the prediction tile unchanged.
- R2: A cycle with ld_all high while idle writes all 16 entries from coef_all. Entry row*4+col sits in bits [16*(row*4+col) +: 16], and the same raster index is used for pred_all (10-bit fields) and for the columns of out_pix (column c in bits [10*c +: 10]).
- R3: A cycle with ld_one high while idle writes ld_val into entry ld_idx (raster index row*4+col). When ld_all and ld_one are both high, the whole-tile load wins.
- R4: Coefficient loads presented while busy is high are ignored.
- R5: Each pixel equals clip(pred + sat16(Z >>> 6), 0, 1023). To get Z, the kernel e0=x0+x2, e1=x0-x2, e2=(x1>>>1)-x3, e3=x1+(x3>>>1), y0=e0+e3, y1=e1+e2, y2=e1-e2, y3=e0-e3 is first applied to each row. Then 32 is added to every element of intermediate row 0. Last, the kernel is applied to each column. The intermediate arithmetic is 32-bit signed.
- R6: Results that fall below 0 are output as 0, and results above 1023 are output as 1023.
- R7: When start is sampled high while idle at clock edge k, rows 0, 1, 2, 3 appear on edges k+3 to k+6, with out_valid high and out_row equal to the row number.
- R8: done is high only in the cycle that carries row 3. busy rises after an accepted start and stays high until that edge. A start while busy produces no extra rows.
- R9: After a run completes, all 16 coefficient entries are zero.
- R10: The prediction tile is sampled on the start edge, and later changes to pred_all do not affect the run in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_all | input | 1 | Load the whole coefficient tile |
| coef_all | input | 256 | 16 signed coefficients, raster order |
| ld_one | input | 1 | Load a single coefficient |
| ld_idx | input | 4 | Raster index for the single load |
| ld_val | input | 16 | Signed value for the single load |
| pred_all | input | 160 | 16 prediction pixels, raster order |
| start | input | 1 | Begin reconstruction of the stored tile |
| busy | output | 1 | A tile is in flight |
| out_valid | output | 1 | out_pix holds a reconstructed row |
| out_row | output | 2 | Row number of out_pix |
| out_pix | output | 40 | Four 10-bit pixels of one row |
| done | output | 1 | Final row of the tile |

## Verification
- **Empty tile.** With an empty store the output must equal the prediction, which separates a correct reset and clear from a stale store.
- **Single coefficients.** A lone DC term shows the rounding bias and the scaling. A lone off-DC term at a known index shows the field layout and the row-then-column order.
- **Random and extreme tiles.** Random full-range tiles test the arithmetic at large. Extreme values paired with black or white predictions drive both clip limits.
- **Activity during a run.** Repeated starts, loads and prediction changes while busy must leave the current tile untouched. A following run with no load must return the bare prediction, which catches both a load that slipped in and a store left uncleared.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
    localparam int TILE    = 4;
    localparam int COEF_W  = 16;
    localparam int PIX_W   = 10;
    localparam int ACC_W   = 32;
    localparam int DOWN_SH = 6;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ROWS,
        PH_COLS,
        PH_EMIT
    } phase_e;
endpackage

// File: rtl/idct4_kernel.sv
module idct4_kernel #(
    parameter int W = idct4_pkg::ACC_W
) (
    input  logic signed [W-1:0] x [4],
    output logic signed [W-1:0] y [4]
);
    logic signed [W-1:0] even_s, even_d, odd_a, odd_b;

    always_comb begin
        even_s = x[0] + x[2];
        even_d = x[0] - x[2];
        odd_a  = (x[1] >>> 1) - x[3];
        odd_b  = x[1] + (x[3] >>> 1);
        y[0]   = even_s + odd_b;
        y[1]   = even_d + odd_a;
        y[2]   = even_d - odd_a;
        y[3]   = even_s - odd_b;
    end
endmodule

// File: rtl/idct4_lane.sv
module idct4_lane #(
    parameter int AW = idct4_pkg::ACC_W,
    parameter int CW = idct4_pkg::COEF_W,
    parameter int PW = idct4_pkg::PIX_W,
    parameter int SH = idct4_pkg::DOWN_SH
) (
    input  logic signed [AW-1:0] acc,
    input  logic [PW-1:0]        pred,
    output logic [PW-1:0]        pix
);
    localparam int RMAX = 2 ** (CW - 1) - 1;
    localparam int RMIN = -(2 ** (CW - 1));
    localparam int PMAX = 2 ** PW - 1;

    logic signed [AW-1:0] scaled;
    logic signed [CW-1:0] resid;
    logic signed [CW:0]   wide_sum;
    logic signed [CW-1:0] sat_sum;

    always_comb begin
        scaled = acc >>> SH;
        if (scaled > AW'(RMAX))      resid = CW'(RMAX);
        else if (scaled < AW'(RMIN)) resid = CW'(RMIN);
        else                         resid = scaled[CW-1:0];

        wide_sum = {resid[CW-1], resid} + $signed({{(CW + 1 - PW){1'b0}}, pred});
        if (wide_sum > (CW+1)'(RMAX))      sat_sum = CW'(RMAX);
        else if (wide_sum < (CW+1)'(RMIN)) sat_sum = CW'(RMIN);
        else                               sat_sum = wide_sum[CW-1:0];

        if (sat_sum < 0)               pix = '0;
        else if (sat_sum > CW'(PMAX))  pix = PW'(PMAX);
        else                           pix = sat_sum[PW-1:0];
    end
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
    import idct4_pkg::*;
#(
    parameter int CW = COEF_W,
    parameter int PW = PIX_W,
    parameter int AW = ACC_W,
    parameter int SH = DOWN_SH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_all,
    input  logic [TILE*TILE*CW-1:0] coef_all,
    input  logic                    ld_one,
    input  logic [3:0]              ld_idx,
    input  logic [CW-1:0]           ld_val,
    input  logic [TILE*TILE*PW-1:0] pred_all,
    input  logic                    start,
    output logic                    busy,
    output logic                    out_valid,
    output logic [1:0]              out_row,
    output logic [TILE*PW-1:0]      out_pix,
    output logic                    done
);
    localparam int NC = TILE * TILE;
    localparam logic signed [AW-1:0] BIAS = AW'(1 << (SH - 1));

    phase_e               phase;
    logic [1:0]           emit_cnt;
    logic signed [CW-1:0] coef_q [NC];
    logic signed [AW-1:0] mid_q  [NC];
    logic signed [AW-1:0] mid_d  [NC];
    logic signed [AW-1:0] res_q  [NC];
    logic signed [AW-1:0] res_d  [NC];
    logic [PW-1:0]        pred_q [NC];
    logic [PW-1:0]        pix_d  [TILE];
    logic [NC*CW-1:0]     coef_flat;
    logic                 last_emit;

    assign busy      = (phase != PH_IDLE);
    assign last_emit = (phase == PH_EMIT) && (emit_cnt == 2'd3);

    // first pass: one kernel per row
    for (genvar r = 0; r < TILE; r++) begin : g_rows
        logic signed [AW-1:0] rin  [4];
        logic signed [AW-1:0] rout [4];
        always_comb begin
            for (int k = 0; k < TILE; k++) begin
                rin[k]            = AW'(coef_q[r*TILE+k]);
                mid_d[r*TILE+k]   = rout[k];
            end
        end
        idct4_kernel #(.W(AW)) u_rk (.x(rin), .y(rout));
    end

    // second pass: one kernel per column, rounding bias on row 0
    for (genvar c = 0; c < TILE; c++) begin : g_cols
        logic signed [AW-1:0] cin  [4];
        logic signed [AW-1:0] cout [4];
        always_comb begin
            for (int k = 0; k < TILE; k++) begin
                cin[k]            = (k == 0) ? mid_q[c] + BIAS : mid_q[k*TILE+c];
                res_d[k*TILE+c]   = cout[k];
            end
        end
        idct4_kernel #(.W(AW)) u_ck (.x(cin), .y(cout));
    end

    // output stage: four lanes for the row being emitted
    for (genvar k = 0; k < TILE; k++) begin : g_lanes
        idct4_lane #(.AW(AW), .CW(CW), .PW(PW), .SH(SH)) u_lane (
            .acc  (res_q[{emit_cnt, 2'(k)}]),
            .pred (pred_q[{emit_cnt, 2'(k)}]),
            .pix  (pix_d[k])
        );
    end

    always_comb begin
        for (int i = 0; i < NC; i++) coef_flat[i*CW +: CW] = coef_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            emit_cnt  <= '0;
            out_valid <= 1'b0;
            out_row   <= '0;
            out_pix   <= '0;
            done      <= 1'b0;
            for (int i = 0; i < NC; i++) coef_q[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (ld_all) begin
                        for (int i = 0; i < NC; i++) coef_q[i] <= coef_all[i*CW +: CW];
                    end else if (ld_one) begin
                        coef_q[ld_idx] <= ld_val;
                    end
                    if (start) phase <= PH_ROWS;
                end
                PH_ROWS: phase <= PH_COLS;
                PH_COLS: begin
                    emit_cnt <= '0;
                    phase    <= PH_EMIT;
                end
                PH_EMIT: begin
                    out_valid <= 1'b1;
                    out_row   <= emit_cnt;
                    for (int k = 0; k < TILE; k++) out_pix[k*PW +: PW] <= pix_d[k];
                    emit_cnt  <= emit_cnt + 2'd1;
                    if (last_emit) begin
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                        for (int i = 0; i < NC; i++) coef_q[i] <= '0;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // datapath registers, no reset needed
    always_ff @(posedge clk) begin
        if (phase == PH_IDLE && start) begin
            for (int i = 0; i < NC; i++) pred_q[i] <= pred_all[i*PW +: PW];
        end
        if (phase == PH_ROWS) mid_q <= mid_d;
        if (phase == PH_COLS) res_q <= res_d;
    end

    // R7
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_row != 2'd3 |=> out_valid && out_row == $past(out_row) + 2'd1);
    // R8
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid && out_row == 2'd3);
    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);
    // R4
    load_block_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !last_emit |=> $stable(coef_flat));
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> coef_flat == '0);
endmodule

// File: tb/sim_idct4_recon.sv
`timescale 1ns/1ps
module sim_idct4_recon;
    logic         clk = 1'b0;
    logic         rst;
    logic         ld_all, ld_one, start;
    logic [255:0] coef_all;
    logic [3:0]   ld_idx;
    logic [15:0]  ld_val;
    logic [159:0] pred_all;
    logic         busy, out_valid, done;
    logic [1:0]   out_row;
    logic [39:0]  out_pix;

    always #2.5 clk = ~clk;

    idct4_recon u0 (
        .clk(clk), .rst(rst), .ld_all(ld_all), .coef_all(coef_all),
        .ld_one(ld_one), .ld_idx(ld_idx), .ld_val(ld_val), .pred_all(pred_all),
        .start(start), .busy(busy), .out_valid(out_valid), .out_row(out_row),
        .out_pix(out_pix), .done(done)
    );

    typedef struct {
        logic [39:0] pix;
        int          row;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   mdl_c [16];
    int   mdl_p [16];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   lat_armed = 0;
    int   lat = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void kern4(input int a0, input int a1, input int a2, input int a3,
                                  output int y0, output int y1, output int y2, output int y3);
        int s, d, p, m;
        s = a0 + a2;  d = a0 - a2;
        p = (a1 >>> 1) - a3;  m = a1 + (a3 >>> 1);
        y0 = s + m;  y1 = d + p;  y2 = d - p;  y3 = s - m;
    endfunction

    task automatic push_expected(input string tag);
        int t [16];
        int o [16];
        int v;
        exp_t e;
        for (int r = 0; r < 4; r++)
            kern4(mdl_c[r*4], mdl_c[r*4+1], mdl_c[r*4+2], mdl_c[r*4+3],
                  t[r*4], t[r*4+1], t[r*4+2], t[r*4+3]);
        for (int c = 0; c < 4; c++) t[c] += 32;
        for (int c = 0; c < 4; c++)
            kern4(t[c], t[4+c], t[8+c], t[12+c], o[c], o[4+c], o[8+c], o[12+c]);
        for (int r = 0; r < 4; r++) begin
            e.pix = '0; e.row = r; e.tag = tag;
            for (int c = 0; c < 4; c++) begin
                v = o[r*4+c] >>> 6;
                if (v > 32767) v = 32767;
                if (v < -32768) v = -32768;
                v = v + mdl_p[r*4+c];
                if (v > 32767) v = 32767;
                if (v < 0) v = 0;
                if (v > 1023) v = 1023;
                e.pix[c*10 +: 10] = 10'(v);
            end
            q.push_back(e);
        end
    endtask

    task automatic set_pred(input int mode);
        for (int i = 0; i < 16; i++) begin
            case (mode)
                0: mdl_p[i] = int'($urandom_range(1023));
                1: mdl_p[i] = 1023;
                2: mdl_p[i] = 0;
                default: mdl_p[i] = ($urandom_range(1)) ? 1023 : 0;
            endcase
            pred_all[i*10 +: 10] = 10'(mdl_p[i]);
        end
    endtask

    task automatic load_par(input int c [16]);
        ld_all = 1'b1;
        for (int i = 0; i < 16; i++) begin
            coef_all[i*16 +: 16] = 16'(c[i]);
            mdl_c[i] = int'($signed(16'(c[i])));
        end
        @(posedge clk); #1;
        ld_all = 1'b0;
    endtask

    task automatic load_ser(input int idx, input int val);
        ld_one = 1'b1; ld_idx = 4'(idx); ld_val = 16'(val);
        mdl_c[idx] = int'($signed(16'(val)));
        @(posedge clk); #1;
        ld_one = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) begin @(posedge clk); #1; end
    endtask

    // disturb: 1 = start, loads and prediction changes while busy
    task automatic launch(input string tag, input bit disturb);
        start = 1'b1;
        push_expected(tag);
        for (int i = 0; i < 16; i++) mdl_c[i] = 0;
        @(posedge clk); #1;
        start = 1'b0;
        if (disturb) begin
            start = 1'b1; ld_one = 1'b1; ld_idx = 4'd3; ld_val = 16'd500;
            ld_all = 1'b1; coef_all = {16{16'h0123}};
            pred_all = ~pred_all;
            @(posedge clk); #1;
            start = 1'b0; ld_one = 1'b0; ld_all = 1'b0;
            pred_all = ~pred_all;
        end
        wait_idle();
    endtask

    function automatic int rnd_coef(input int span);
        return int'($urandom_range(2 * span)) - span;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (lat_armed) lat++;
            if (out_valid) begin
                if (lat_armed) begin
                    // R7 latency from accepted start
                    chk(lat == 4 && out_row == 2'd0, "R7", "first row latency", lat, 4);
                    lat_armed = 0;
                end
                if (q.size() == 0) begin
                    chk(0, "R8", "row with no pending tile", out_row, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(out_pix == e.pix, e.tag, "row pixels", out_pix, e.pix);
                    chk(int'(out_row) == e.row, "R7", "row order", out_row, e.row);
                    chk(done == (e.row == 3), "R8", "done on last row", done, e.row == 3);
                end
            end else if (done) begin
                chk(0, "R8", "done without row", done, 0);
            end
            if (start && !busy) begin
                lat_armed = 1; lat = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c [16];
        rst = 1'b1; ld_all = 0; ld_one = 0; start = 0;
        coef_all = '0; ld_idx = '0; ld_val = '0; pred_all = '0;
        for (int i = 0; i < 16; i++) begin mdl_c[i] = 0; mdl_p[i] = 0; end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && out_valid == 0 && done == 0, "R1", "reset outputs",
            {busy, out_valid, done}, 0);
        @(posedge clk); #1;

        // R1 empty store returns prediction
        set_pred(0);
        launch("R1", 0);

        // R2 DC term only: +1 on every pixel
        for (int i = 0; i < 16; i++) c[i] = 0;
        c[0] = 64;
        set_pred(0);
        load_par(c);
        launch("R2", 0);

        // R2 single off-DC term at row 1 column 2
        for (int i = 0; i < 16; i++) c[i] = 0;
        c[6] = 1000;
        set_pred(0);
        load_par(c);
        launch("R2", 0);

        // R5 random tiles
        for (int n = 0; n < 6; n++) begin
            for (int i = 0; i < 16; i++) c[i] = rnd_coef(2000);
            set_pred(0);
            load_par(c);
            launch("R5", 0);
        end

        // R3 single-entry loads
        set_pred(0);
        load_ser(0, 300);
        load_ser(9, -700);
        load_ser(15, 1234);
        load_ser(4, -90);
        launch("R3", 0);

        // R3 whole-tile load wins over single load
        for (int i = 0; i < 16; i++) c[i] = rnd_coef(500);
        ld_one = 1'b1; ld_idx = 4'd7; ld_val = 16'd3000;
        set_pred(0);
        load_par(c);
        ld_one = 1'b0;
        launch("R3", 0);

        // R6 clip high and low
        for (int i = 0; i < 16; i++) c[i] = 0;
        c[0] = 32767;
        for (int i = 0; i < 16; i++) begin
            mdl_p[i] = 1000; pred_all[i*10 +: 10] = 10'd1000;
        end
        load_par(c);
        launch("R6", 0);
        c[0] = -32768;
        for (int i = 0; i < 16; i++) begin
            mdl_p[i] = 300; pred_all[i*10 +: 10] = 10'd300;
        end
        load_par(c);
        launch("R6", 0);

        // R6 extreme tiles against black and white predictions
        for (int n = 0; n < 6; n++) begin
            for (int i = 0; i < 16; i++) c[i] = ($urandom_range(1)) ? 32767 : -32768;
            set_pred(1 + n % 3);
            load_par(c);
            launch("R6", 0);
        end

        // R10 R8 R4 activity while busy
        for (int i = 0; i < 16; i++) c[i] = rnd_coef(3000);
        set_pred(0);
        load_par(c);
        launch("R10", 1);
        // R9 R4 store must be empty afterwards
        set_pred(0);
        launch("R9", 0);

        // R5 mixed random, full range
        for (int n = 0; n < 20; n++) begin
            for (int i = 0; i < 16; i++) c[i] = rnd_coef((n % 2) ? 32767 : 200);
            set_pred(n % 4);
            load_par(c);
            launch("R5", n % 5 == 0);
        end

        repeat (10) @(posedge clk);
        #1;
        // R8 no extra rows remain expected or emitted
        chk(q.size() == 0, "R8", "pending rows at end", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule